// File: doc/BRIEF.md
# Cascadable TDM Frame Serializer

This block builds one 256-bit serial TDM frame per frame period. It places its own left and right samples in the first two 32-bit slots of the frame. The rest of the frame is filled with the serial stream it receives from an upstream unit, delayed by exactly two slots. Several units can share one bit clock and one frame sync, with each unit's serial output feeding the next unit's chain input. The last unit in a chain of four then carries eight channels. Its order is the nearest unit's pair first and the head unit's pair last. The head of the chain ties its chain input low, so the slots it does not fill read as zero.

The block runs entirely on the bit clock, which is 256 times the frame rate, and uses the rising edge for every register. Timing is described in bit positions 0..255. "Position p" is the bit period that `ser_out` presents after a rising edge. A runtime select chooses the role:

- As master, the block generates the frame sync itself from a free-running position counter.
- As slave, it aligns its counter to an incoming frame sync.

A second select chooses left-justified framing or I2S framing. In I2S framing every data bit comes one bit period later and the sync polarity is inverted.

Top module: `tdm_cascade_tx`

## Requirements
- R1: While `rst` is high at a rising edge, `ser_out` and `frame_out` are 0 after that edge. The sample holds and the chain delay are cleared, so the own slots and the chain slots read zero until new data has been captured or received.
- R2: In master role the first edge after reset release presents position 255 and the next edge presents position 0. The position then advances by one per edge and wraps after 255. `frame_out` is 1 for positions 0..127 and 0 for 128..255 in left-justified framing, and the inverse in I2S framing.
- R3: Slot k covers positions 32k..32k+31. In left-justified framing, slot 0 carries the captured left sample and slot 1 the captured right sample, bit 23 first. I2S framing moves every bit one position later, so each sample's bit 23 appears at positions 1 and 33.
- R4: The eight positions following bit 0 in slots 0 and 1 are always 0 when the block is aligned. In left-justified framing these are positions 24..31 and 56..63.
- R5: The `chain_in` value sampled at the edge that ends position p appears on `ser_out` at position p+64 (mod 256). In left-justified framing these bits fill slots 2..7.
- R6: `left_smp` and `right_smp` are captured once per frame, at the aligned edge that presents position 255. A change at any other edge does not alter the frame being sent.
- R7: In master role `frame_in` has no effect on `ser_out` or `frame_out`.
- R8: In slave role `frame_out` is always 0. `ser_out` stays 0 until the first frame edge has been sampled.
- R9: In slave role a frame edge sets the position to 1 at the sampling edge, and this applies at every such edge, including one that arrives mid-frame. A frame edge is `frame_in` sampled 0 then 1 on consecutive edges in left-justified framing, or 1 then 0 in I2S framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 256 periods per frame |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | 1: generate frame sync, 0: follow `frame_in` |
| i2s_mode | input | 1 | 0: left-justified framing, 1: I2S framing |
| frame_in | input | 1 | Incoming frame sync (slave role) |
| chain_in | input | 1 | Serial TDM stream from the upstream unit |
| left_smp | input | 24 | Left sample, two's complement |
| right_smp | input | 24 | Right sample, two's complement |
| frame_out | output | 1 | Generated frame sync (master role), else 0 |
| ser_out | output | 1 | Serial TDM frame output |

## Verification
The bench builds the default parameters: 24-bit samples in 32-bit slots, eight slots per frame, and a 63-tap chain delay. These values put the whole 256-position frame, the wrap of the I2S shift across the frame boundary and the pad bits all within a few thousand cycles. Both roles are run in both framings. The slave runs include a frame sync that jumps mid-frame, and the master runs drive `frame_in` with random values.

// File: rtl/tdm_cas_pkg.sv
`timescale 1ns/1ps
package tdm_cas_pkg;
  // Source of the bit presented at one frame position
  typedef enum logic [1:0] {
    SRC_PAD   = 2'd0,
    SRC_OWN   = 2'd1,
    SRC_CHAIN = 2'd2
  } bit_src_e;
endpackage

// File: rtl/tdm_frame_timer.sv
`timescale 1ns/1ps
module tdm_frame_timer #(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_sel,
  input  logic             i2s_mode,
  input  logic             frame_in,
  output logic [POS_W-1:0] pos_nx,
  output logic             lock_nx,
  output logic [POS_W-1:0] pos_q,
  output logic             locked_q,
  output logic             frame_out
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] HALF = POS_W'(FRAME_BITS / 2);
  localparam logic [POS_W-1:0] ONE  = POS_W'(1);

  logic             fs_q;
  logic             sync_edge;
  logic [POS_W-1:0] pos_inc;

  // frame sync history is kept through reset so the edge test is valid at once
  always_ff @(posedge clk) fs_q <= frame_in;

  always_comb begin
    sync_edge = i2s_mode ? (fs_q & ~frame_in) : (~fs_q & frame_in);
    pos_inc   = (pos_q == LAST) ? '0 : pos_q + ONE;
    if (master_sel) begin
      pos_nx  = pos_inc;
      lock_nx = 1'b1;
    end else begin
      pos_nx  = sync_edge ? ONE : pos_inc;
      lock_nx = locked_q | sync_edge;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= master_sel ? LAST - ONE : LAST;
      locked_q  <= 1'b0;
      frame_out <= 1'b0;
    end else begin
      pos_q     <= pos_nx;
      locked_q  <= lock_nx;
      frame_out <= master_sel & ((pos_nx < HALF) ^ i2s_mode);
    end
  end
endmodule

// File: rtl/tdm_sample_hold.sv
`timescale 1ns/1ps
module tdm_sample_hold #(
  parameter int CHANS    = 2,
  parameter int SAMPLE_W = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cap_en,
  input  logic [CHANS-1:0][SAMPLE_W-1:0] smp_in,
  output logic [CHANS-1:0][SAMPLE_W-1:0] hold_q
);
  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst)         hold_q[c] <= '0;
      else if (cap_en) hold_q[c] <= smp_in[c];
    end
  end
endmodule

// File: rtl/tdm_chain_delay.sv
`timescale 1ns/1ps
module tdm_chain_delay #(
  parameter int DEPTH = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  if (DEPTH == 1) begin : g_single
    logic tap_q;
    always_ff @(posedge clk) begin
      if (rst) tap_q <= 1'b0;
      else     tap_q <= din;
    end
    assign dout = tap_q;
  end else begin : g_shift
    logic [DEPTH-1:0] line_q;
    always_ff @(posedge clk) begin
      if (rst) line_q <= '0;
      else     line_q <= {line_q[DEPTH-2:0], din};
    end
    assign dout = line_q[DEPTH-1];
  end
endmodule

// File: rtl/tdm_slot_mux.sv
`timescale 1ns/1ps
module tdm_slot_mux
  import tdm_cas_pkg::*;
#(
  parameter int CHANS     = 2,
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_W    = 32,
  parameter int SLOTS     = 8,
  parameter int POS_W     = $clog2(SLOT_W * SLOTS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [POS_W-1:0]               pos_nx,
  input  logic                           lock_nx,
  input  logic                           i2s_mode,
  input  logic [CHANS-1:0][SAMPLE_W-1:0] hold_q,
  input  logic                           chain_bit,
  output logic                           ser_out
);
  localparam int OFF_W = $clog2(SLOT_W);
  localparam int IDX_W = POS_W - OFF_W;
  localparam logic [POS_W-1:0] LAST = POS_W'(SLOT_W * SLOTS - 1);

  logic [POS_W-1:0]    q_pos;
  logic [IDX_W-1:0]    slot;
  logic [OFF_W-1:0]    off;
  logic [SAMPLE_W-1:0] sel_smp;
  logic [SAMPLE_W-1:0] shifted;
  bit_src_e            src;
  logic                nx_bit;

  always_comb begin
    // I2S framing moves every data bit one position later
    if (i2s_mode) q_pos = (pos_nx == '0) ? LAST : pos_nx - POS_W'(1);
    else          q_pos = pos_nx;
    slot = q_pos[POS_W-1:OFF_W];
    off  = q_pos[OFF_W-1:0];

    sel_smp = '0;
    for (int c = 0; c < CHANS; c++) begin
      if (int'(slot) == c) sel_smp = hold_q[c];
    end
    shifted = sel_smp << off;

    if (int'(slot) >= CHANS)        src = SRC_CHAIN;
    else if (int'(off) >= SAMPLE_W) src = SRC_PAD;
    else                            src = SRC_OWN;

    unique case (src)
      SRC_OWN:   nx_bit = shifted[SAMPLE_W-1];
      SRC_CHAIN: nx_bit = chain_bit;
      default:   nx_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ser_out <= 1'b0;
    else     ser_out <= lock_nx & nx_bit;
  end
endmodule

// File: rtl/tdm_cascade_tx.sv
`timescale 1ns/1ps
module tdm_cascade_tx #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                master_sel,
  input  logic                i2s_mode,
  input  logic                frame_in,
  input  logic                chain_in,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  output logic                frame_out,
  output logic                ser_out
);
  localparam int CHANS      = 2;
  localparam int FRAME_BITS = SLOT_W * SLOTS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int DLY_DEPTH  = CHANS * SLOT_W - 1;
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0]               pos_nx;
  logic [POS_W-1:0]               pos_q;
  logic                           lock_nx;
  logic                           locked_q;
  logic                           cap_en;
  logic                           chain_bit;
  logic [CHANS-1:0][SAMPLE_W-1:0] smp_pack;
  logic [CHANS-1:0][SAMPLE_W-1:0] hold_q;

  assign smp_pack = {right_smp, left_smp};
  assign cap_en   = lock_nx & (pos_nx == LAST);

  tdm_frame_timer #(
    .FRAME_BITS (FRAME_BITS),
    .POS_W      (POS_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .master_sel (master_sel),
    .i2s_mode   (i2s_mode),
    .frame_in   (frame_in),
    .pos_nx     (pos_nx),
    .lock_nx    (lock_nx),
    .pos_q      (pos_q),
    .locked_q   (locked_q),
    .frame_out  (frame_out)
  );

  tdm_sample_hold #(
    .CHANS    (CHANS),
    .SAMPLE_W (SAMPLE_W)
  ) u_hold (
    .clk    (clk),
    .rst    (rst),
    .cap_en (cap_en),
    .smp_in (smp_pack),
    .hold_q (hold_q)
  );

  tdm_chain_delay #(
    .DEPTH (DLY_DEPTH)
  ) u_delay (
    .clk  (clk),
    .rst  (rst),
    .din  (chain_in),
    .dout (chain_bit)
  );

  tdm_slot_mux #(
    .CHANS    (CHANS),
    .SAMPLE_W (SAMPLE_W),
    .SLOT_W   (SLOT_W),
    .SLOTS    (SLOTS),
    .POS_W    (POS_W)
  ) u_mux (
    .clk       (clk),
    .rst       (rst),
    .pos_nx    (pos_nx),
    .lock_nx   (lock_nx),
    .i2s_mode  (i2s_mode),
    .hold_q    (hold_q),
    .chain_bit (chain_bit),
    .ser_out   (ser_out)
  );
endmodule

// File: rtl/tdm_cascade_chk.sv
`timescale 1ns/1ps
module tdm_cascade_chk #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8,
  parameter int POS_W    = $clog2(SLOT_W * SLOTS)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        master_sel,
  input logic                        i2s_mode,
  input logic                        frame_in,
  input logic                        frame_out,
  input logic                        ser_out,
  input logic [POS_W-1:0]            pos_q,
  input logic                        locked_q,
  input logic [1:0][SAMPLE_W-1:0]    hold_q
);
  localparam int OFF_W = $clog2(SLOT_W);
  localparam logic [POS_W-1:0] LAST = POS_W'(SLOT_W * SLOTS - 1);

  logic             rst_d;
  logic [POS_W-1:0] q_disp;
  logic             pad_pos;

  always_ff @(posedge clk) rst_d <= rst;

  always_comb begin
    q_disp  = i2s_mode ? ((pos_q == '0) ? LAST : pos_q - POS_W'(1)) : pos_q;
    pad_pos = (int'(q_disp[POS_W-1:OFF_W]) < 2) && (int'(q_disp[OFF_W-1:0]) >= SAMPLE_W);
  end

  always_ff @(posedge clk) begin
    if (rst_d) begin
      AST_RST_QUIET: assert (ser_out == 1'b0 && frame_out == 1'b0); // R1
    end
  end

  AST_MASTER_STEP: assert property (@(posedge clk) disable iff (rst)
    master_sel |=> (pos_q == (($past(pos_q) == LAST) ? '0 : $past(pos_q) + POS_W'(1)))); // R2

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    pad_pos |-> !ser_out); // R4

  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !$stable(hold_q) |-> (pos_q == LAST && locked_q)); // R6

  AST_UNLOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !locked_q |-> !ser_out); // R8

  AST_SLAVE_FRAME_LOW: assert property (@(posedge clk) disable iff (rst)
    !master_sel |=> !frame_out); // R8

  AST_SLAVE_SYNC_LJ: assert property (@(posedge clk) disable iff (rst)
    (!master_sel && !i2s_mode && $rose(frame_in)) |=> (pos_q == POS_W'(1) && locked_q)); // R9

  AST_SLAVE_SYNC_I2S: assert property (@(posedge clk) disable iff (rst)
    (!master_sel && i2s_mode && $fell(frame_in)) |=> (pos_q == POS_W'(1) && locked_q)); // R9
endmodule

bind tdm_cascade_tx tdm_cascade_chk #(
  .SAMPLE_W (SAMPLE_W),
  .SLOT_W   (SLOT_W),
  .SLOTS    (SLOTS),
  .POS_W    (POS_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .master_sel (master_sel),
  .i2s_mode   (i2s_mode),
  .frame_in   (frame_in),
  .frame_out  (frame_out),
  .ser_out    (ser_out),
  .pos_q      (pos_q),
  .locked_q   (locked_q),
  .hold_q     (hold_q)
);

// File: tb/tb_tdm_cascade_tx.sv
`timescale 1ns/1ps
module tb_tdm_cascade_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        master_sel = 1'b1;
  logic        i2s_mode = 1'b0;
  logic        frame_in = 1'b0;
  logic        chain_in = 1'b0;
  logic [23:0] left_smp = '0;
  logic [23:0] right_smp = '0;
  logic        frame_out;
  logic        ser_out;

  always #2.5 clk = ~clk;

  tdm_cascade_tx dut (
    .clk        (clk),
    .rst        (rst),
    .master_sel (master_sel),
    .i2s_mode   (i2s_mode),
    .frame_in   (frame_in),
    .chain_in   (chain_in),
    .left_smp   (left_smp),
    .right_smp  (right_smp),
    .frame_out  (frame_out),
    .ser_out    (ser_out)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string note = "";

  // reference state derived from the requirements
  int          dp;
  bit          lk;
  bit          fsq;
  logic [23:0] exp_l, exp_r;
  bit          smp_hist [4096];
  int          m;
  int          up;

  function automatic bit lvl(int p, bit i2s);
    return (p < 128) ^ i2s;
  endfunction

  function automatic int qpos(int p, bit i2s);
    return i2s ? (p + 255) % 256 : p;
  endfunction

  function automatic bit exp_bit(int p, bit i2s, logic [23:0] l, logic [23:0] r, bit ch);
    int q = qpos(p, i2s);
    int s = q / 32;
    int o = q % 32;
    if (s < 2) begin
      if (o >= 24) return 1'b0;
      return (s == 0) ? l[23 - o] : r[23 - o];
    end
    return ch;
  endfunction

  function automatic string tag_of(int p, bit i2s);
    int q = qpos(p, i2s);
    if (q / 32 >= 2) return "R5";
    if (q % 32 >= 24) return "R4";
    return "R3";
  endfunction

  task automatic check(logic act, logic exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s %s: actual=%0b expected=%0b (edge %0d, pos %0d)",
               req, note, what, act, exp, m, dp);
    end
  endtask

  task automatic tick();
    bit samp;
    bit syn;
    bit ch;
    bit e;
    @(posedge clk);
    samp = frame_in;
    syn  = i2s_mode ? (fsq && !samp) : (!fsq && samp);
    fsq  = samp;
    if (rst) begin
      dp = master_sel ? 254 : 255;
      lk = 1'b0;
      exp_l = '0;
      exp_r = '0;
      m = 0;
    end else begin
      m++;
      if (master_sel) begin
        dp = (dp + 1) % 256;
        lk = 1'b1;
      end else begin
        dp = syn ? 1 : (dp + 1) % 256;
        lk = lk | syn;
      end
      smp_hist[m] = chain_in;
      if (lk && dp == 255) begin  // R6 capture point
        exp_l = left_smp;
        exp_r = right_smp;
      end
    end
    @(negedge clk);
    if (rst) begin
      check(ser_out, 1'b0, "R1", "ser_out in reset");
      check(frame_out, 1'b0, "R1", "frame_out in reset");
    end else begin
      ch = (m >= 64) ? smp_hist[m - 63] : 1'b0;
      e  = lk ? exp_bit(dp, i2s_mode, exp_l, exp_r, ch) : 1'b0;
      check(ser_out, e, lk ? tag_of(dp, i2s_mode) : "R8", "ser_out");
      if (master_sel) check(frame_out, lvl(dp, i2s_mode), "R2", "frame_out");
      else            check(frame_out, 1'b0, "R8", "frame_out");
    end
  endtask

  task automatic run_phase(bit ms, bit i2s, int cycles, int jump_at, string tag);
    note       = tag;
    rst        = 1'b1;
    master_sel = ms;
    i2s_mode   = i2s;
    up         = 200;
    frame_in   = ms ? 1'b0 : lvl(up, i2s);
    chain_in   = 1'b0;
    for (int k = 0; k < 4096; k++) smp_hist[k] = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    for (int n = 0; n < cycles; n++) begin
      up = (n == jump_at) ? (up + 37) % 256 : (up + 1) % 256;  // R9 mid-frame jump
      frame_in = ms ? 1'($urandom % 2) : lvl(up, i2s);          // R7 noise in master
      chain_in = (n < 300) ? 1'b1 : 1'($urandom % 2);           // R4 pads against all-ones
      if (n == 0) begin
        left_smp  = 24'h800001;
        right_smp = 24'h7FFFFE;
      end else if ($urandom % 40 == 0) begin                    // R6 changes mid-frame
        left_smp  = 24'($urandom);
        right_smp = 24'($urandom);
      end
      tick();
    end
  endtask

  initial begin
    void'($urandom(32'd914));
    run_phase(1'b1, 1'b0, 1100, -1, "master-lj R7");
    run_phase(1'b1, 1'b1, 900, -1, "master-i2s R7");
    run_phase(1'b0, 1'b0, 1100, 500, "slave-lj R9");
    run_phase(1'b0, 1'b1, 1100, 620, "slave-i2s R9");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule